// File: doc/BRIEF.md
# One-Time-Programmable Byte Store: Mode Decode and Identification

This block is a synthesizable, clock-cycle model of the control side of a byte-wide one-time-programmable memory. It turns the chip-select, output-enable and program-strobe lines, plus two level flags, into one operating mode. The flags say whether the programming supply is raised and whether the high-voltage identification level is present on the designated address pin. From that mode it decides four things: whether the byte bus is driven, what value it carries, whether an incoming byte is burned into the internal array, and when the fixed identification bytes are returned instead of array contents.

Analog timing is expressed in clock cycles. Data becomes valid only after each of three conditions has held for its own number of sampled edges: a stable address, an asserted chip select and an asserted output enable. The bus is also held for a parameterised number of cycles after either select is released. The array starts fully erased (all ones), and programming can only clear bits. A test harness or a system model uses the block in place of a real device and controls it purely through its pins.

Top module: `eprm_core`

## Requirements
- R1: During and after reset, with both selects high, `dout_oe` and `dout_vld` are 0 and every array byte reads back as 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, no identification condition and the supply flag low, the block drives the stored byte at the sampled address once the access delays are met.
- R3: A select that is high in the sampled inputs means `dout_vld` is 0 after that edge, and the bus is released once the float delay has run out.
- R4: When `ce_n`=0, `oe_n`=1, `pgm_n`=0 and `vpp_hi`=1 are sampled at an edge, the addressed byte becomes its old value ANDed with `din`. With `vpp_hi`=0, no write takes place.
- R5: When `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `vpp_hi`=1, the block drives the stored byte (verify).
- R6: With `ce_n`=1 and `vpp_hi`=1, no byte is written even if `pgm_n`=0, and the bus is released after the float delay.
- R7: When `ce_n`=0, `oe_n`=0 and `a9_hv`=1 with every address bit above bit 0 at zero, the block drives 0x1E for `addr[0]`=0 and 0x86 for `addr[0]`=1. If any upper address bit is set, the array is read instead.
- R8: `dout_vld` rises only after the address together with `a9_hv` has been sampled unchanged on T_ACC edges, `ce_n` low on T_CE edges and `oe_n` low on T_OE edges. A change restarts its count. While waiting, the bus is driven with `dout`=0.
- R9: When a readable mode is left, `dout_oe` stays high for T_DF more cycles with `dout_vld`=0, and `dout` holds the last valid byte.
- R10: `dout` is 0 whenever `dout_oe` is 0, and `dout_vld` is never 1 without `dout_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| a9_hv | input | 1 | High-voltage level present on the identification address pin |
| vpp_hi | input | 1 | Programming supply at programming level |
| addr | input | AW | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Output byte |
| dout_oe | output | 1 | Bus driven (0 means high impedance) |
| dout_vld | output | 1 | Output byte is valid |

## Verification
A corrupted mode register or access counter appears at the ports within one cycle. It shows up as `dout_vld` rising too early or too late against the counted edges, or as `dout_oe` lingering or dropping against the float count. A bad array write stays hidden until that address is read back. For that reason, programmed bytes are read back after further programming attempts, both with and without the supply flag and with chip select high. A behavioural reference model is compared on every clock, so a mismatch is reported in the cycle it first becomes visible.

// File: rtl/eprm_pkg.sv
package eprm_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_INHIBIT,
        MD_OUTOFF,
        MD_PROG,
        MD_READ,
        MD_VERIFY,
        MD_IDENT
    } eprm_mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic a9_hv;
        logic vpp_hi;
    } eprm_ctl_t;

    localparam logic [7:0] ID_CODE_LO = 8'h1E;
    localparam logic [7:0] ID_CODE_HI = 8'h86;

    function automatic logic drives_bus(input eprm_mode_e m);
        return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
    endfunction

endpackage

// File: rtl/eprm_mode_dec.sv
module eprm_mode_dec
    import eprm_pkg::*;
#(
    parameter int AW = 6
) (
    input  eprm_ctl_t        ctl,
    input  logic [AW-1:0]    addr,
    output eprm_mode_e       mode
);
    logic upper_zero;

    always_comb begin
        upper_zero = (addr[AW-1:1] == '0);
        if (ctl.ce_n)
            mode = ctl.vpp_hi ? MD_INHIBIT : MD_STANDBY;
        else if (ctl.oe_n)
            mode = (ctl.vpp_hi && !ctl.pgm_n) ? MD_PROG : MD_OUTOFF;
        else if (ctl.a9_hv && upper_zero)
            mode = MD_IDENT;
        else if (ctl.vpp_hi && ctl.pgm_n)
            mode = MD_VERIFY;
        else
            mode = MD_READ;
    end
endmodule

// File: rtl/eprm_age_cnt.sv
module eprm_age_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_zero,
    input  logic restart,
    output logic ready
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (hold_zero)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= CW'(1);
        else if (cnt_q != LIM)
            cnt_q <= cnt_q + CW'(1);
    end

    assign ready = (cnt_q == LIM);

    // R8
    zero_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        hold_zero |=> !ready);
endmodule

// File: rtl/eprm_cell_array.sv
module eprm_cell_array #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];

    // R4
    and_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((mem[$past(waddr)] & ~$past(wdata)) == 8'h00));
endmodule

// File: rtl/eprm_core.sv
module eprm_core
    import eprm_pkg::*;
#(
    parameter int AW    = 6,
    parameter int T_ACC = 4,
    parameter int T_CE  = 4,
    parameter int T_OE  = 2,
    parameter int T_DF  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          pgm_n,
    input  logic          a9_hv,
    input  logic          vpp_hi,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic          dout_oe,
    output logic          dout_vld
);
    localparam int FW = $clog2(T_DF + 1) > 0 ? $clog2(T_DF + 1) : 1;
    localparam logic [FW-1:0] FLT_INIT = FW'(T_DF);

    eprm_ctl_t  ctl;
    eprm_mode_e mode_nx, mode_q;
    logic [AW-1:0] addr_q;
    logic [AW:0]   key_q;
    logic [FW-1:0] flt_q;
    logic [7:0]    hold_q, rdata, cur_data;
    logic          a_rdy, c_rdy, o_rdy, key_chg, rd_q, rd_nx, vld;

    assign ctl = '{ce_n: ce_n, oe_n: oe_n, pgm_n: pgm_n, a9_hv: a9_hv, vpp_hi: vpp_hi};

    eprm_mode_dec #(.AW(AW)) i_dec (.ctl(ctl), .addr(addr), .mode(mode_nx));

    assign key_chg = ({a9_hv, addr} != key_q);

    eprm_age_cnt #(.LIMIT(T_ACC)) i_age_addr (
        .clk(clk), .rst(rst), .hold_zero(1'b0), .restart(key_chg), .ready(a_rdy));
    eprm_age_cnt #(.LIMIT(T_CE)) i_age_ce (
        .clk(clk), .rst(rst), .hold_zero(ce_n), .restart(1'b0), .ready(c_rdy));
    eprm_age_cnt #(.LIMIT(T_OE)) i_age_oe (
        .clk(clk), .rst(rst), .hold_zero(oe_n), .restart(1'b0), .ready(o_rdy));

    eprm_cell_array #(.AW(AW)) i_cells (
        .clk(clk), .rst(rst), .wr_en(mode_nx == MD_PROG), .waddr(addr), .wdata(din),
        .raddr(addr_q), .rdata(rdata));

    assign rd_q  = drives_bus(mode_q);
    assign rd_nx = drives_bus(mode_nx);
    assign cur_data = (mode_q == MD_IDENT) ? (addr_q[0] ? ID_CODE_HI : ID_CODE_LO) : rdata;
    assign vld = rd_q && a_rdy && c_rdy && o_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_STANDBY;
            addr_q <= '0;
            key_q  <= '0;
            flt_q  <= '0;
            hold_q <= '0;
        end else begin
            mode_q <= mode_nx;
            addr_q <= addr;
            key_q  <= {a9_hv, addr};
            if (vld) hold_q <= cur_data;
            if (rd_nx)
                flt_q <= '0;
            else if (rd_q)
                flt_q <= FLT_INIT;
            else if (flt_q != '0)
                flt_q <= flt_q - FW'(1);
        end
    end

    assign dout_vld = vld;
    assign dout_oe  = rd_q || (flt_q != '0);
    assign dout     = vld ? cur_data : ((flt_q != '0) ? hold_q : 8'h00);

    // R10
    vld_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> dout_oe);
    // R10
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == 8'h00));
    // R3
    ce_release_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !dout_vld);
    // R3
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !dout_vld);
endmodule

// File: tb/test_eprm_core.sv
module test_eprm_core;
    localparam int AW = 6, T_ACC = 4, T_CE = 4, T_OE = 2, T_DF = 2;
    localparam int DEPTH = 1 << AW;
    localparam int K_STBY = 0, K_INH = 1, K_OFF = 2, K_PROG = 3, K_RD = 4, K_VER = 5, K_ID = 6;

    logic clk = 0, rst = 1;
    logic ce_n = 1, oe_n = 1, pgm_n = 1, a9_hv = 0, vpp_hi = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_oe, dout_vld;

    int checks = 0, fails = 0;
    string phase = "R1";
    bit cmp_on = 0;

    eprm_core #(.AW(AW), .T_ACC(T_ACC), .T_CE(T_CE), .T_OE(T_OE), .T_DF(T_DF)) i_eprm_core (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .a9_hv(a9_hv),
        .vpp_hi(vpp_hi), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .dout_vld(dout_vld));

    always #5 clk = ~clk;

    // behavioural reference
    logic [7:0] ref_mem [DEPTH];
    int m_mode, a_age, c_age, o_age, flt;
    logic [AW:0] m_key;
    logic [AW-1:0] m_addr;
    logic [7:0] hold, e_cur, e_dout;
    logic e_oe, e_vld;

    function automatic int decode(logic c, logic o, logic p, logic h, logic v, logic [AW-1:0] a);
        if (c) return v ? K_INH : K_STBY;
        if (o) return (v && !p) ? K_PROG : K_OFF;
        if (h && (a >> 1) == 0) return K_ID;
        if (v && p) return K_VER;
        return K_RD;
    endfunction

    function automatic bit readable(int m);
        return m == K_RD || m == K_VER || m == K_ID;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
            m_mode = K_STBY; a_age = 0; c_age = 0; o_age = 0; flt = 0;
            m_key = '0; m_addr = '0; hold = '0;
        end else begin
            int nm;
            nm = decode(ce_n, oe_n, pgm_n, a9_hv, vpp_hi, addr);
            if (e_vld) hold = e_cur;
            if ({a9_hv, addr} != m_key) a_age = 1;
            else if (a_age < T_ACC) a_age++;
            m_key = {a9_hv, addr};
            c_age = ce_n ? 0 : (c_age < T_CE ? c_age + 1 : c_age);
            o_age = oe_n ? 0 : (o_age < T_OE ? o_age + 1 : o_age);
            if (nm == K_PROG) ref_mem[addr] = ref_mem[addr] & din;
            if (readable(nm)) flt = 0;
            else if (readable(m_mode)) flt = T_DF;
            else if (flt > 0) flt--;
            m_mode = nm; m_addr = addr;
        end
        e_cur = (m_mode == K_ID) ? (m_addr[0] ? 8'h86 : 8'h1E) : ref_mem[m_addr];
        e_vld = readable(m_mode) && a_age >= T_ACC && c_age >= T_CE && o_age >= T_OE;
        e_oe  = readable(m_mode) || flt > 0;
        e_dout = e_vld ? e_cur : (flt > 0 ? hold : 8'h00);
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (dout !== e_dout || dout_oe !== e_oe || dout_vld !== e_vld) begin
                fails++;
                $display("FAIL %s model: got dout=%h oe=%b vld=%b expected dout=%h oe=%b vld=%b",
                         phase, dout, dout_oe, dout_vld, e_dout, e_oe, e_vld);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic set_in(logic c, logic o, logic p, logic h, logic v, logic [AW-1:0] a, logic [7:0] d);
        ce_n = c; oe_n = o; pgm_n = p; a9_hv = h; vpp_hi = v; addr = a; din = d;
    endtask

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        cyc(3);
        rst = 0;
        cmp_on = 1;
        cyc(1);
        chk("R1", {7'd0, dout_oe}, 8'h00);
        chk("R1", dout, 8'h00);

        // R8 / R2: read of an erased byte
        phase = "R8";
        set_in(0, 0, 1, 0, 0, 6'd5, 8'h00);
        cyc(3);
        chk("R8", {6'd0, dout_oe, dout_vld}, 8'h02);
        cyc(1);
        phase = "R2";
        chk("R2", {7'd0, dout_vld}, 8'h01);
        chk("R2", dout, 8'hFF);

        // R4: two program pulses AND together
        phase = "R4";
        set_in(0, 1, 0, 0, 1, 6'd5, 8'hF0);
        cyc(1);
        chk("R9", {6'd0, dout_oe, dout_vld}, 8'h02);
        chk("R9", dout, 8'hFF);
        din = 8'h3C;
        cyc(1);
        set_in(0, 0, 1, 0, 0, 6'd5, 8'h00);
        cyc(1);
        chk("R8", {7'd0, dout_vld}, 8'h00);
        cyc(1);
        chk("R4", dout, 8'h30);

        // R4: no write without supply flag
        set_in(0, 1, 0, 0, 0, 6'd5, 8'h00);
        cyc(2);
        set_in(0, 0, 1, 0, 0, 6'd5, 8'h00);
        cyc(2);
        chk("R4", dout, 8'h30);

        // R5: verify
        phase = "R5";
        set_in(0, 0, 1, 0, 1, 6'd5, 8'h00);
        cyc(1);
        chk("R5", {7'd0, dout_vld}, 8'h01);
        chk("R5", dout, 8'h30);

        // R6 / R9 / R3: inhibit and float
        phase = "R6";
        set_in(1, 1, 0, 0, 1, 6'd5, 8'h00);
        cyc(1);
        chk("R9", {6'd0, dout_oe, dout_vld}, 8'h02);
        chk("R9", dout, 8'h30);
        cyc(1);
        chk("R9", {7'd0, dout_oe}, 8'h01);
        cyc(1);
        chk("R3", {7'd0, dout_oe}, 8'h00);
        chk("R10", dout, 8'h00);
        set_in(0, 0, 1, 0, 0, 6'd5, 8'h00);
        cyc(3);
        chk("R8", {7'd0, dout_vld}, 8'h00);
        cyc(1);
        chk("R6", dout, 8'h30);

        // R7: identification
        phase = "R7";
        set_in(0, 0, 1, 1, 0, 6'd0, 8'h00);
        cyc(3);
        chk("R8", {7'd0, dout_vld}, 8'h00);
        cyc(1);
        chk("R7", dout, 8'h1E);
        addr = 6'd1;
        cyc(4);
        chk("R7", dout, 8'h86);
        addr = 6'd2;
        cyc(4);
        chk("R7", dout, 8'hFF);
        a9_hv = 0;
        cyc(3);
        chk("R8", {7'd0, dout_vld}, 8'h00);
        cyc(1);
        chk("R8", dout, 8'hFF);

        // R4: top address
        phase = "R4";
        set_in(0, 1, 0, 0, 1, 6'd63, 8'h5A);
        cyc(1);
        set_in(0, 0, 1, 0, 0, 6'd63, 8'h00);
        cyc(4);
        chk("R4", dout, 8'h5A);

        // R2: mixed traffic against the model
        phase = "R2";
        for (int i = 0; i < 600; i++) begin
            set_in($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
                   $urandom_range(0, 4) == 0, $urandom_range(0, 2) == 0,
                   AW'($urandom_range(0, 7)), 8'($urandom));
            cyc($urandom_range(1, 6));
        end
        cyc(2);
        summary();
    end
endmodule